// File: doc/BRIEF.md
# Dead-Time Pulse-Width Modulator with Mid-Ramp Sample Strobe

This block drives the two switches of a synchronous step-down converter from a free-running up-counter. A duty command sets how long the high-side gate stays on in each switching period. The low-side gate is driven as the complement of the high-side gate. A fixed guard interval is inserted at both transitions, so the two switches never conduct together.

The block also emits a one-clock strobe at the middle of the high-side on-interval. At that point the inductor current crosses its average value, so the strobe is used as the trigger and enable for the sample-and-hold and the converter's ADC. The duty command is sampled once per period, on the last count, so a command that changes during a period never produces a partial pulse.

An external asynchronous active-low reset is synchronised inside the block before it reaches the counter and the output registers.

Top module: `buck_dpwm`

## Requirements
- R1: While the reset input is low, gate_hi, gate_lo and sample_strobe are all low.
- R2: The internal count runs from 0 to 2^CNT_W-1 and wraps to 0, so one period lasts 2^CNT_W clocks (4096 at the default).
- R3: gate_hi is high in the clock after each count c for which DEAD_CNT <= c < D, where D is the duty value active for that period. If D <= DEAD_CNT, gate_hi stays low for the whole period.
- R4: gate_lo is high in the clock after each count c for which D+DEAD_CNT <= c <= 2^CNT_W-1. If D+DEAD_CNT exceeds 2^CNT_W-1, gate_lo stays low for the whole period.
- R5: gate_hi and gate_lo are never high in the same clock. Between the fall of either output and the rise of the other there are at least DEAD_CNT clocks with both outputs low.
- R6: sample_strobe is high for exactly one clock per period, in the clock after the count equals floor(D/2).
- R7: duty_cmd is captured only on the clock edge at which the count is 2^CNT_W-1, and it takes effect from count 0 of the next period. A change at any other time does not affect the current period's outputs.
- R8: After reset is released, the count first advances on the third rising clock edge. The first period runs with D = 0, so sample_strobe is first high after that third edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock (count rate) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| duty_cmd | input | CNT_W | Requested high-side on-count for the next period |
| gate_hi | output | 1 | High-side switch drive |
| gate_lo | output | 1 | Low-side switch drive |
| sample_strobe | output | 1 | One-clock pulse at the midpoint of the high-side on-interval |

## Verification
On every clock, the embedded assertions check four things:
- the two gates never overlap;
- each gate rises only after the required quiet gap;
- the count advances by one or wraps;
- the active duty value changes only at a period boundary.

The strobe is also checked to never last longer than one clock. The bench's scenarios are needed to show that each edge lands at the exact count derived from the duty value. They also show the boundary duty values (zero, at and just above the dead count, near full scale) and the two-edge reset release. Finally, they show that a command changed in mid-period waits for the wrap.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int unsigned DEF_CNT_W = 12;
  localparam int unsigned DEF_DEAD  = 2;

  typedef struct packed {
    logic hi;
    logic lo;
    logic smp;
  } gate_bus_t;
endpackage

// File: rtl/dpwm_rst_sync.sv
module dpwm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/dpwm_counter.sv
module dpwm_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic             last_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    last_cnt = (cnt_q == CNT_MAX);
    cnt_d    = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2: the count either steps by one or wraps from the top value to zero
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  assert_count_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_cnt |=> (cnt_q == '0));
endmodule

// File: rtl/dpwm_duty_reg.sv
module dpwm_duty_reg #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] duty_in,
  output logic [CNT_W-1:0] duty_q
);
  logic [CNT_W-1:0] duty_d;

  always_comb begin
    duty_d = load_en ? duty_in : duty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) duty_q <= '0;
    else        duty_q <= duty_d;
  end

  // R7: the active duty only moves on the edge that follows a boundary load
  assert_duty_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(duty_q));
endmodule

// File: rtl/dpwm_gate_gen.sv
module dpwm_gate_gen
  import dpwm_pkg::*;
#(
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned DEAD_CNT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty,
  output gate_bus_t        gates_q
);
  localparam int unsigned      EXT_W    = CNT_W + 1;
  localparam logic [EXT_W-1:0] DEAD_EXT = EXT_W'(DEAD_CNT);
  localparam int unsigned      GAP_W    = $clog2(DEAD_CNT + 1) + 1;
  localparam logic [GAP_W-1:0] GAP_SAT  = GAP_W'(DEAD_CNT);

  logic [EXT_W-1:0] cnt_ext;
  logic [EXT_W-1:0] duty_ext;
  logic [EXT_W-1:0] lo_start;
  gate_bus_t        gates_d;

  always_comb begin
    cnt_ext     = {1'b0, cnt};
    duty_ext    = {1'b0, duty};
    lo_start    = duty_ext + DEAD_EXT;
    gates_d.hi  = (cnt_ext >= DEAD_EXT) && (cnt_ext < duty_ext);
    gates_d.lo  = (cnt_ext >= lo_start);
    gates_d.smp = (cnt == (duty >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gates_q <= '0;
    else        gates_q <= gates_d;
  end

  // quiet-interval tracker used only by the checks below
  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] gap_d;

  always_comb begin
    if (gates_q.hi || gates_q.lo) gap_d = '0;
    else if (gap_q < GAP_SAT)     gap_d = gap_q + 1'b1;
    else                          gap_d = gap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= GAP_SAT;
    else        gap_q <= gap_d;
  end

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(gates_q.hi && gates_q.lo));
  assert_lo_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gates_q.lo) |-> (gap_q >= GAP_SAT));
  assert_hi_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gates_q.hi) |-> (gap_q >= GAP_SAT));
  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gates_q.smp |=> !gates_q.smp);
endmodule

// File: rtl/buck_dpwm.sv
module buck_dpwm
  import dpwm_pkg::*;
#(
  parameter int unsigned CNT_W    = DEF_CNT_W,
  parameter int unsigned DEAD_CNT = DEF_DEAD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] duty_cmd,
  output logic             gate_hi,
  output logic             gate_lo,
  output logic             sample_strobe
);
  logic             rst_n_int;
  logic [CNT_W-1:0] cnt;
  logic             last_cnt;
  logic [CNT_W-1:0] duty_act;
  gate_bus_t        gates;

  initial begin
    assert (DEAD_CNT >= 1 && DEAD_CNT < (1 << (CNT_W - 1)))
      else $error("DEAD_CNT out of range");
  end

  dpwm_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  dpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .cnt_en   (1'b1),
    .cnt_q    (cnt),
    .last_cnt (last_cnt)
  );

  dpwm_duty_reg #(.CNT_W(CNT_W)) u_duty (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .load_en (last_cnt),
    .duty_in (duty_cmd),
    .duty_q  (duty_act)
  );

  dpwm_gate_gen #(.CNT_W(CNT_W), .DEAD_CNT(DEAD_CNT)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .cnt     (cnt),
    .duty    (duty_act),
    .gates_q (gates)
  );

  assign gate_hi       = gates.hi;
  assign gate_lo       = gates.lo;
  assign sample_strobe = gates.smp;

  // R1: every output is low while the external reset is held
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!gate_hi && !gate_lo && !sample_strobe));
endmodule

// File: tb/buck_dpwm_test.sv
module buck_dpwm_test;
  localparam int W    = 12;
  localparam int DEAD = 2;
  localparam int MAXC = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] duty_cmd;
  logic         gate_hi, gate_lo, sample_strobe;

  int checks = 0;
  int errors = 0;
  bit run_chk = 1'b0;
  longint cyc = 0;

  buck_dpwm #(.CNT_W(W), .DEAD_CNT(DEAD)) uut (
    .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .sample_strobe(sample_strobe)
  );

  always #5 clk = ~clk;

  function automatic bit f_hi(int c, int d);
    return (c >= DEAD) && (c < d);
  endfunction
  function automatic bit f_lo(int c, int d);
    return (c >= d + DEAD) && (c <= MAXC);
  endfunction
  function automatic bit f_smp(int c, int d);
    return c == (d / 2);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // reference model of the requirement timing
  bit m_s1 = 0, m_s2 = 0;
  int m_cnt = 0, m_duty = 0;
  bit e_hi = 0, e_lo = 0, e_smp = 0;
  always @(posedge clk) begin
    cyc++;
    if (!m_s2) begin
      m_cnt = 0; m_duty = 0; e_hi = 0; e_lo = 0; e_smp = 0;
    end else begin
      e_hi  = f_hi(m_cnt, m_duty);
      e_lo  = f_lo(m_cnt, m_duty);
      e_smp = f_smp(m_cnt, m_duty);
      if (m_cnt == MAXC) m_duty = int'(duty_cmd);   // R7
      m_cnt = (m_cnt == MAXC) ? 0 : m_cnt + 1;      // R2
    end
    m_s2 = rst_n ? m_s1 : 1'b0;
    m_s1 = rst_n;
  end

  always @(negedge clk) begin
    if (run_chk) begin
      chk("R3 gate_hi", gate_hi, e_hi);
      chk("R4 gate_lo", gate_lo, e_lo);
      chk("R6 sample_strobe", sample_strobe, e_smp);
      chk("R5 no overlap", gate_hi & gate_lo, 0);
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int directed [8] = '{0, 1, 2, 3, 2048, 4093, 4094, 4095};
    int hi_cnt;
    void'($urandom(32'h5eed_0017));
    rst_n = 1'b0;
    duty_cmd = W'(1000);
    step(4);
    chk("R1 reset gate_hi", gate_hi, 0);
    chk("R1 reset gate_lo", gate_lo, 0);
    chk("R1 reset strobe", sample_strobe, 0);
    rst_n = 1'b1;
    step(2);
    chk("R8 no strobe before third edge", sample_strobe, 0);
    step(1);
    chk("R8 first strobe after third edge", sample_strobe, 1);
    run_chk = 1'b1;
    // first period runs with duty 0: count gate_hi cycles (R3) over it
    hi_cnt = 0;
    for (int i = 0; i < MAXC; i++) begin
      @(negedge clk);
      if (gate_hi) hi_cnt++;
    end
    chk("R7 first period uses zero duty", hi_cnt, 0);
    // directed corner duties, changed at a mid-period point
    foreach (directed[k]) begin
      duty_cmd = W'(directed[k]);
      step(MAXC + 1 + 700);
      duty_cmd = W'($urandom % (MAXC + 1));   // mid-period change, must wait for wrap (R7)
      step(300);
    end
    // random duties at random moments
    for (int r = 0; r < 14; r++) begin
      duty_cmd = W'($urandom % (MAXC + 1));
      step(MAXC + 1 + int'($urandom % 2048));
    end
    run_chk = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule